// File: doc/BRIEF.md
# Instruction Fault Status Register Unit

This block keeps the cause of the most recent instruction-side abort in a 32-bit system register that sits on a coprocessor-style register access port. The fetch and translation logic reports a fault as a single-cycle pulse that carries a fault kind. The block turns that kind into a 4-bit status code and stores it. A debugger or the abort handler reads the register through the access port. A debugger can also write the register to restore a saved state.

An access names its target with four coordinate fields. The block responds only when all four match its own address. It then classifies the access and registers a one-cycle response in an access state machine. The state machine has four states:
- `ST_IDLE`: no response.
- `ST_RD`: read data valid.
- `ST_WR`: write acknowledged.
- `ST_TRAP`: undefined-instruction trap.

Every state is entered from any state in the cycle after a request. A selected privileged read leads to `ST_RD`. A selected privileged write leads to `ST_WR`. A selected user-mode read or write leads to `ST_TRAP`. No request, or a request for other coordinates, leads to `ST_IDLE`. A trap leaves the stored status unchanged. An access for other coordinates is left for other registers to claim.

Top module: `ifsr_unit`

## Requirements
- R1: After reset the stored status is 4'b0000 (no fault), and none of `rsp_rd_valid`, `rsp_wr_ack` and `rsp_undef` is high.
- R2: A pulse on `flt_valid` with kind K stores a code. The mapping of K to code is:
  - 0 alignment → 0001
  - 1 debug event → 0010
  - 2 translation on section → 0101
  - 3 translation on page → 0111
  - 4 access flag on section → 0011
  - 5 access flag on page → 0110
  - 6 domain on section → 1001
  - 7 domain on page → 1011
  - 8 permission on section → 1101
  - 9 permission on page → 1111
  - 10 precise external abort → 1000
  - 11 first-level translation external abort → 1100
  - 12 second-level translation external abort → 1110
- R3: Fault capture never stores 0100 or 1010. A pulse with kind 13, 14 or 15 leaves the stored status unchanged.
- R4: The register is selected only when op1 = 0, CRn = 5, CRm = 0 and op2 = 1. For any other coordinates, no response is raised in the next cycle and the status is unchanged.
- R5: A selected privileged read (`acc_write`=0, `acc_priv`=1) drives `rsp_rd_valid` high in the next cycle. In that cycle `rsp_rdata` holds the status as it was before the request edge in bits [3:0], and zero in bits [31:4], including bit 10.
- R6: A selected privileged write loads `acc_wdata[3:0]` into the status and drives `rsp_wr_ack` high in the next cycle. Bits [31:4] of the written data are dropped.
- R7: A selected access with `acc_priv`=0, whether read or write, drives `rsp_undef` high in the next cycle. It raises neither `rsp_rd_valid` nor `rsp_wr_ack`, and it leaves the status unchanged.
- R8: Each fault pulse overwrites the stored status, so the register holds the code of the last fault.
- R9: When a fault pulse and a selected privileged write fall in the same cycle, the fault code is stored.
- R10: At most one of the three response outputs is high in any cycle. `rsp_rdata` is zero whenever `rsp_rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Instruction fault pulse |
| flt_kind | input | 4 | Fault kind, numbered as in R2 |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| acc_op1 | input | 3 | First opcode coordinate |
| acc_crn | input | 4 | Primary register coordinate |
| acc_crm | input | 4 | Secondary register coordinate |
| acc_op2 | input | 3 | Second opcode coordinate |
| acc_wdata | input | 32 | Write data |
| rsp_rd_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rsp_wr_ack | output | 1 | Write accepted |
| rsp_undef | output | 1 | Undefined-instruction trap |

## Verification
Every result of this block is due exactly one edge after its stimulus:
- The status register updates on the edge that ends a fault pulse or a write request.
- The access response shows in the cycle after the request edge.

A read issued in the same cycle as a fault therefore returns the old code. A second read then returns the new one. The bench drives inputs on the falling edge and holds them across one rising edge. It then samples every response at the next falling edge, the single cycle in which that response is due. The stored status is only ever observed through a later privileged read.

// File: rtl/ifsr_pkg.sv
package ifsr_pkg;

    localparam int STAT_W = 4;
    localparam int KIND_W = 4;

    typedef logic [STAT_W-1:0] stat_t;

    typedef enum logic [KIND_W-1:0] {
        FK_ALIGN      = 4'd0,
        FK_DEBUG      = 4'd1,
        FK_XLAT_SEC   = 4'd2,
        FK_XLAT_PAGE  = 4'd3,
        FK_AFLAG_SEC  = 4'd4,
        FK_AFLAG_PAGE = 4'd5,
        FK_DOM_SEC    = 4'd6,
        FK_DOM_PAGE   = 4'd7,
        FK_PERM_SEC   = 4'd8,
        FK_PERM_PAGE  = 4'd9,
        FK_EXT_PREC   = 4'd10,
        FK_EXT_WALK1  = 4'd11,
        FK_EXT_WALK2  = 4'd12
    } fault_kind_e;

    localparam stat_t CODE_NONE = 4'b0000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_TRAP = 2'd3
    } acc_state_e;

endpackage

// File: rtl/ifsr_fault_enc.sv
module ifsr_fault_enc
    import ifsr_pkg::*;
(
    input  logic              flt_valid,
    input  logic [KIND_W-1:0] flt_kind,
    output logic              cap_en,
    output stat_t             cap_code
);

    logic  known;
    stat_t code;

    always_comb begin
        known = 1'b1;
        code  = CODE_NONE;
        case (flt_kind)
            FK_ALIGN:      code = 4'b0001;
            FK_DEBUG:      code = 4'b0010;
            FK_XLAT_SEC:   code = 4'b0101;
            FK_XLAT_PAGE:  code = 4'b0111;
            FK_AFLAG_SEC:  code = 4'b0011;
            FK_AFLAG_PAGE: code = 4'b0110;
            FK_DOM_SEC:    code = 4'b1001;
            FK_DOM_PAGE:   code = 4'b1011;
            FK_PERM_SEC:   code = 4'b1101;
            FK_PERM_PAGE:  code = 4'b1111;
            FK_EXT_PREC:   code = 4'b1000;
            FK_EXT_WALK1:  code = 4'b1100;
            FK_EXT_WALK2:  code = 4'b1110;
            default:       known = 1'b0;
        endcase
    end

    assign cap_en   = flt_valid && known;
    assign cap_code = code;

endmodule

// File: rtl/ifsr_sel_decode.sv
module ifsr_sel_decode #(
    parameter int OP1_W  = 3,
    parameter int CRN_W  = 4,
    parameter int CRM_W  = 4,
    parameter int OP2_W  = 3,
    parameter int OP1_ID = 0,
    parameter int CRN_ID = 5,
    parameter int CRM_ID = 0,
    parameter int OP2_ID = 1
) (
    input  logic             acc_valid,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output logic             hit
);

    localparam logic [OP1_W-1:0] OP1_V = OP1_ID[OP1_W-1:0];
    localparam logic [CRN_W-1:0] CRN_V = CRN_ID[CRN_W-1:0];
    localparam logic [CRM_W-1:0] CRM_V = CRM_ID[CRM_W-1:0];
    localparam logic [OP2_W-1:0] OP2_V = OP2_ID[OP2_W-1:0];

    logic [3:0] field_ok;

    always_comb begin
        field_ok[0] = (op1 == OP1_V);
        field_ok[1] = (crn == CRN_V);
        field_ok[2] = (crm == CRM_V);
        field_ok[3] = (op2 == OP2_V);
    end

    assign hit = acc_valid && (&field_ok);

endmodule

// File: rtl/ifsr_access_fsm.sv
module ifsr_access_fsm
    import ifsr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              is_write,
    input  logic              is_priv,
    input  stat_t             stat_now,
    output logic              wr_commit,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ack,
    output logic              undef
);

    localparam int PAD_W = DATA_W - STAT_W;

    acc_state_e state_q, state_d;
    stat_t      snap_q;

    always_comb begin
        state_d = ST_IDLE;
        if (hit) begin
            unique case ({is_priv, is_write})
                2'b10:   state_d = ST_RD;
                2'b11:   state_d = ST_WR;
                default: state_d = ST_TRAP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            snap_q  <= CODE_NONE;
        end else begin
            state_q <= state_d;
            if (state_d == ST_RD) begin
                snap_q <= stat_now;
            end
        end
    end

    assign wr_commit = (state_d == ST_WR);

    always_comb begin
        rd_valid = 1'b0;
        wr_ack   = 1'b0;
        undef    = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD: begin
                rd_valid = 1'b1;
                rd_data  = {{PAD_W{1'b0}}, snap_q};
            end
            ST_WR:   wr_ack = 1'b1;
            ST_TRAP: undef  = 1'b1;
        endcase
    end

endmodule

// File: rtl/ifsr_status_reg.sv
module ifsr_status_reg
    import ifsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cap_en,
    input  stat_t cap_code,
    input  logic  wr_en,
    input  stat_t wr_val,
    output stat_t stat_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= CODE_NONE;
        end else if (cap_en) begin
            stat_q <= cap_code;
        end else if (wr_en) begin
            stat_q <= wr_val;
        end
    end

endmodule

// File: rtl/ifsr_unit.sv
module ifsr_unit
    import ifsr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OP1_W  = 3,
    parameter int CRN_W  = 4,
    parameter int CRM_W  = 4,
    parameter int OP2_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic [KIND_W-1:0] flt_kind,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic [OP1_W-1:0]  acc_op1,
    input  logic [CRN_W-1:0]  acc_crn,
    input  logic [CRM_W-1:0]  acc_crm,
    input  logic [OP2_W-1:0]  acc_op2,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rsp_rd_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_wr_ack,
    output logic              rsp_undef
);

    logic  cap_en;
    stat_t cap_code;
    logic  sel_hit;
    logic  wr_commit;
    stat_t stat_cur;
    stat_t wr_low;

    assign wr_low = acc_wdata[STAT_W-1:0];

    ifsr_fault_enc u_enc (
        .flt_valid (flt_valid),
        .flt_kind  (flt_kind),
        .cap_en    (cap_en),
        .cap_code  (cap_code)
    );

    ifsr_sel_decode #(
        .OP1_W (OP1_W),
        .CRN_W (CRN_W),
        .CRM_W (CRM_W),
        .OP2_W (OP2_W)
    ) u_sel (
        .acc_valid (acc_valid),
        .op1       (acc_op1),
        .crn       (acc_crn),
        .crm       (acc_crm),
        .op2       (acc_op2),
        .hit       (sel_hit)
    );

    ifsr_access_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (sel_hit),
        .is_write  (acc_write),
        .is_priv   (acc_priv),
        .stat_now  (stat_cur),
        .wr_commit (wr_commit),
        .rd_valid  (rsp_rd_valid),
        .rd_data   (rsp_rdata),
        .wr_ack    (rsp_wr_ack),
        .undef     (rsp_undef)
    );

    ifsr_status_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_code (cap_code),
        .wr_en    (wr_commit),
        .wr_val   (wr_low),
        .stat_q   (stat_cur)
    );

endmodule

// File: rtl/ifsr_unit_chk.sv
module ifsr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flt_valid,
    input logic [3:0]  flt_kind,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_priv,
    input logic [2:0]  acc_op1,
    input logic [3:0]  acc_crn,
    input logic [3:0]  acc_crm,
    input logic [2:0]  acc_op2,
    input logic        rsp_rd_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_wr_ack,
    input logic        rsp_undef,
    input logic [3:0]  stat
);

    logic addr_ok;
    assign addr_ok = (acc_op1 == 3'd0) && (acc_crn == 4'd5) &&
                     (acc_crm == 4'd0) && (acc_op2 == 3'd1);

    // R10
    a_r10_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_rd_valid, rsp_wr_ack, rsp_undef}));

    // R10
    a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_rd_valid |-> (rsp_rdata == 32'd0));

    // R5
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rd_valid |-> (rsp_rdata[31:4] == 28'd0));

    // R7
    a_r7_user_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && addr_ok && !acc_priv) |=> (rsp_undef && !rsp_rd_valid && !rsp_wr_ack));

    // R7
    a_r7_user_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && addr_ok && !acc_priv && !flt_valid) |=> $stable(stat));

    // R4
    a_r4_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !addr_ok) |=> (!rsp_rd_valid && !rsp_wr_ack && !rsp_undef));

    // R3
    a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_kind <= 4'd12) |=> (stat != 4'b0100 && stat != 4'b1010 && stat != 4'b0000));

    // R3
    a_r3_bad_kind_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_kind > 4'd12 && !acc_valid) |=> $stable(stat));

    // R6
    a_r6_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && addr_ok && acc_priv && acc_write) |=> rsp_wr_ack);

endmodule

bind ifsr_unit ifsr_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flt_valid    (flt_valid),
    .flt_kind     (flt_kind),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_priv     (acc_priv),
    .acc_op1      (acc_op1),
    .acc_crn      (acc_crn),
    .acc_crm      (acc_crm),
    .acc_op2      (acc_op2),
    .rsp_rd_valid (rsp_rd_valid),
    .rsp_rdata    (rsp_rdata),
    .rsp_wr_ack   (rsp_wr_ack),
    .rsp_undef    (rsp_undef),
    .stat         (u_reg.stat_q)
);

// File: tb/tb_ifsr_unit.sv
`timescale 1ns/1ps
module tb_ifsr_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flt_valid;
    logic [3:0]  flt_kind;
    logic        acc_valid;
    logic        acc_write;
    logic        acc_priv;
    logic [2:0]  acc_op1;
    logic [3:0]  acc_crn;
    logic [3:0]  acc_crm;
    logic [2:0]  acc_op2;
    logic [31:0] acc_wdata;
    logic        rsp_rd_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_wr_ack;
    logic        rsp_undef;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic        g_rd, g_ack, g_undef;
    logic [31:0] g_data;

    // kind in the high nibble, expected code in the low nibble (R2)
    localparam logic [7:0] VEC [0:12] = '{
        8'h01, 8'h12, 8'h25, 8'h37, 8'h43, 8'h56, 8'h69,
        8'h7B, 8'h8D, 8'h9F, 8'hA8, 8'hBC, 8'hCE
    };

    always #2 clk = ~clk;

    ifsr_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .flt_valid    (flt_valid),
        .flt_kind     (flt_kind),
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_priv     (acc_priv),
        .acc_op1      (acc_op1),
        .acc_crn      (acc_crn),
        .acc_crm      (acc_crm),
        .acc_op2      (acc_op2),
        .acc_wdata    (acc_wdata),
        .rsp_rd_valid (rsp_rd_valid),
        .rsp_rdata    (rsp_rdata),
        .rsp_wr_ack   (rsp_wr_ack),
        .rsp_undef    (rsp_undef)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flt_valid = 0; flt_kind = 0; acc_valid = 0; acc_write = 0; acc_priv = 0;
        acc_op1 = 0; acc_crn = 0; acc_crm = 0; acc_op2 = 0; acc_wdata = 0;
    endtask

    // drives one request cycle, samples the response at the following negedge
    task automatic access(input bit wr, input bit pv, input logic [2:0] o1, input logic [3:0] cn,
                          input logic [3:0] cm, input logic [2:0] o2, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_priv = pv;
        acc_op1 = o1; acc_crn = cn; acc_crm = cm; acc_op2 = o2; acc_wdata = wd;
        @(negedge clk);
        idle_inputs();
        g_rd = rsp_rd_valid; g_ack = rsp_wr_ack; g_undef = rsp_undef; g_data = rsp_rdata;
    endtask

    task automatic priv_read(output logic [31:0] d);
        access(0, 1, 3'd0, 4'd5, 4'd0, 3'd1, 32'd0);
        d = g_data;
    endtask

    task automatic fault(input logic [3:0] k);
        @(negedge clk);
        flt_valid = 1; flt_kind = k;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check(!rsp_rd_valid && !rsp_wr_ack && !rsp_undef, "R1 no response after reset",
              {29'd0, rsp_rd_valid, rsp_wr_ack, rsp_undef}, 32'd0);
        priv_read(d);
        check(g_rd && d == 32'd0, "R1 reset status", d, 32'd0);

        // R2 / R8 vector walk: each fault overwrites the previous one
        for (int i = 0; i < 13; i++) begin
            fault(VEC[i][7:4]);
            priv_read(d);
            check(g_rd && d == {28'd0, VEC[i][3:0]}, "R2 R8 fault code", d, {28'd0, VEC[i][3:0]});
            check(d[10] == 1'b0 && d[31:4] == 28'd0, "R5 upper bits zero", d, {28'd0, VEC[i][3:0]});
        end

        // R3 unknown kinds ignored
        for (int k = 13; k < 16; k++) begin
            fault(4'(k));
            priv_read(d);
            check(d == 32'hE, "R3 unknown kind ignored", d, 32'hE);
        end

        // R6 write restores, upper bits dropped
        access(1, 1, 3'd0, 4'd5, 4'd0, 3'd1, 32'hFFFF_FFF3);
        check(g_ack && !g_rd && !g_undef, "R6 write ack", {29'd0, g_rd, g_ack, g_undef}, 32'd2);
        priv_read(d);
        check(d == 32'h3, "R6 write value", d, 32'h3);
        access(1, 1, 3'd0, 4'd5, 4'd0, 3'd1, 32'h0000_000A);
        priv_read(d);
        check(d == 32'hA, "R6 write any low code", d, 32'hA);

        // R7 user read and write trap, no change
        access(0, 0, 3'd0, 4'd5, 4'd0, 3'd1, 32'd0);
        check(g_undef && !g_rd && !g_ack && g_data == 0, "R7 user read traps",
              {29'd0, g_rd, g_ack, g_undef}, 32'd1);
        access(1, 0, 3'd0, 4'd5, 4'd0, 3'd1, 32'h5);
        check(g_undef && !g_ack, "R7 user write traps", {29'd0, g_rd, g_ack, g_undef}, 32'd1);
        priv_read(d);
        check(d == 32'hA, "R7 user write no change", d, 32'hA);

        // R4 each mismatched coordinate: no response, no change
        access(1, 1, 3'd1, 4'd5, 4'd0, 3'd1, 32'h1);
        check(!g_rd && !g_ack && !g_undef, "R4 op1 mismatch", {29'd0, g_rd, g_ack, g_undef}, 32'd0);
        access(1, 1, 3'd0, 4'd6, 4'd0, 3'd1, 32'h1);
        check(!g_rd && !g_ack && !g_undef, "R4 crn mismatch", {29'd0, g_rd, g_ack, g_undef}, 32'd0);
        access(1, 0, 3'd0, 4'd5, 4'd1, 3'd1, 32'h1);
        check(!g_rd && !g_ack && !g_undef, "R4 crm mismatch user", {29'd0, g_rd, g_ack, g_undef}, 32'd0);
        access(0, 1, 3'd0, 4'd5, 4'd0, 3'd0, 32'h0);
        check(!g_rd && !g_ack && !g_undef && g_data == 0, "R4 op2 mismatch",
              {29'd0, g_rd, g_ack, g_undef}, 32'd0);
        priv_read(d);
        check(d == 32'hA, "R4 status unchanged", d, 32'hA);

        // R9 fault and privileged write in the same cycle: fault wins
        @(negedge clk);
        flt_valid = 1; flt_kind = 4'd8;
        acc_valid = 1; acc_write = 1; acc_priv = 1;
        acc_op1 = 0; acc_crn = 5; acc_crm = 0; acc_op2 = 1; acc_wdata = 32'h2;
        @(negedge clk);
        idle_inputs();
        priv_read(d);
        check(d == 32'hD, "R9 fault beats write", d, 32'hD);

        // R5 read in the same cycle as a fault returns the older code
        @(negedge clk);
        flt_valid = 1; flt_kind = 4'd0;
        acc_valid = 1; acc_write = 0; acc_priv = 1;
        acc_op1 = 0; acc_crn = 5; acc_crm = 0; acc_op2 = 1;
        @(negedge clk);
        idle_inputs();
        check(rsp_rd_valid && rsp_rdata == 32'hD, "R5 read sees pre-edge value", rsp_rdata, 32'hD);
        @(negedge clk);
        check(!rsp_rd_valid && rsp_rdata == 0, "R10 response is one cycle", rsp_rdata, 32'd0);
        priv_read(d);
        check(d == 32'h1, "R8 later read sees new fault", d, 32'h1);

        // R1 reset clears a stored code
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        priv_read(d);
        check(d == 32'd0, "R1 reset clears status", d, 32'd0);

        finish_run();
    end

endmodule